// File: doc/BRIEF.md
# SD Card Command Response Receiver

This block listens to the card's command line after the host has sent a command and captures whatever reply the command calls for. A command-start pulse carries a 2-bit reply-type code. The code selects one of four cases: no reply, a short 48-bit reply whose CRC7 is checked, a long 136-bit reply whose CRC7 is checked, or a short reply taken as it arrives with no CRC check. The receiver then waits for the start bit. A programmable limit bounds that wait. When the start bit arrives, the receiver shifts in the frame one bit per clock and loads the payload into a small halfword FIFO.

Three sticky status flags report the outcome: reply finished, reply timed out and reply CRC mismatch. Software clears each flag by writing a one to it. The payload is drained one 16-bit halfword per read strobe, high half first. A short reply gives three halfwords. A long reply gives eight halfwords, which pair up into four 32-bit words.

Top module: `sdrsp_capture`

## Requirements
- R1: A command start with reply code 0 captures nothing. The done flag is set at the first clock edge after the start pulse, the timeout flag stays clear, and the read port returns zero.
- R2: With code 1 or 3, the first low sample of `cmd_in` after the start pulse is bit 47 of a 48-bit frame. The frame arrives MSB first. The done flag rises at the edge that samples frame bit 0 and not earlier. The FIFO then holds frame bits [47:32], [31:16] and [15:0] in that read order, so the last halfword carries frame bits [15:8] in its upper byte.
- R3: With code 2, the frame is 136 bits long. The FIFO holds frame bits [127:0] as eight halfwords, starting with [127:112].
- R4: With code 1, a CRC7 (polynomial x^7+x^3+1, initial value 0, MSB-first) is computed over frame bits [47:8] and compared with frame bits [7:1]. A mismatch sets the CRC flag when the done flag is set.
- R5: With code 2, the CRC7 covers frame bits [127:8] only. A change to frame bits [135:128] does not set the CRC flag.
- R6: With code 3, no CRC check is made, and a wrong CRC field does not set the CRC flag.
- R7: If `tmo_limit` consecutive high samples follow the start pulse without a start bit, the timeout flag and the done flag are both set at the edge of the last of those samples. The FIFO stays empty.
- R8: Each flag is sticky until a one is written to its bit of `sts_clr`: bit 0 clears done, bit 1 clears timeout, bit 2 clears CRC error. A zero bit leaves its flag unchanged.
- R9: Each `rd_en` cycle advances the read pointer by one halfword. Once all loaded halfwords have been read, and whenever the FIFO is empty, `rd_data` is zero.
- R10: A command start flushes any unread halfwords. From the next edge, `rd_data` is zero.
- R11: A start bit sampled in the `tmo_limit`-th cycle after the start pulse is still accepted, and no timeout is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card-side sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle pulse when a command has gone out |
| rsp_kind | input | 2 | Reply type: 0 none, 1 short+CRC, 2 long, 3 short raw |
| tmo_limit | input | TMO_W | Maximum wait for the start bit, in clocks |
| cmd_in | input | 1 | Serial command-line input, idle high |
| sts_clr | input | 3 | Write-one-to-clear strobes {crc, timeout, done} |
| rd_en | input | 1 | Pop one halfword from the reply FIFO |
| rd_data | output | 16 | Halfword at the head of the FIFO, zero when empty |
| sts_end | output | 1 | Reply complete (or no reply expected) |
| sts_tmo | output | 1 | No start bit within the limit |
| sts_crc | output | 1 | CRC7 mismatch on a checked reply |

## Verification
Every result is due at a fixed edge:
- The done flag for code 0 is due at the first edge after the start pulse.
- The timeout flag is due at the edge that takes the `tmo_limit`-th high sample.
- For a frame of N bits, the done and CRC flags and the FIFO contents are due at the edge that samples the last bit. That edge comes N-1 edges after the start bit was sampled.

The bench drives inputs and samples outputs on the falling edge, so each check falls half a cycle after the edge that is due to produce its result. Where a boundary matters, the bench checks once a cycle earlier to confirm that the flag is still low: the last bit of a frame, and the edge just before the timeout. Each `rd_en` pulse is followed by a check one falling edge later, because the pointer moves at the rising edge in between.

// File: rtl/sdrsp_pkg.sv
package sdrsp_pkg;

    localparam int SHORT_LEN  = 48;
    localparam int LONG_LEN   = 136;
    localparam int HW_W       = 16;
    localparam int FIFO_DEPTH = 8;
    localparam int SHORT_HW   = SHORT_LEN / HW_W;
    localparam int LONG_HW    = 128 / HW_W;
    localparam int PAYLOAD_W  = 127;          // stored bits; the live input bit completes 128
    localparam int SHORT_TOP  = SHORT_LEN - 1;
    localparam int LONG_TOP   = 127;
    localparam int CNT_W      = $clog2(LONG_LEN + 1);
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
    localparam int IDX_W      = $clog2(FIFO_DEPTH);

    typedef enum logic [1:0] {
        RSP_NONE      = 2'd0,
        RSP_SHORT_CRC = 2'd1,
        RSP_LONG      = 2'd2,
        RSP_SHORT_RAW = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SHIFT
    } rx_state_e;

    typedef struct packed {
        logic crc;
        logic tmo;
        logic done;
    } rx_flags_t;

    function automatic logic [CNT_W-1:0] frame_last(input rsp_kind_e k);
        return (k == RSP_LONG) ? CNT_W'(LONG_LEN - 1) : CNT_W'(SHORT_LEN - 1);
    endfunction

    function automatic logic crc_covers(input rsp_kind_e k, input logic [CNT_W-1:0] pos);
        if (k == RSP_LONG)
            return (pos >= CNT_W'(8)) && (pos < CNT_W'(128));
        return pos < CNT_W'(SHORT_LEN - 8);
    endfunction

    function automatic logic crc_checked(input rsp_kind_e k);
        return (k == RSP_SHORT_CRC) || (k == RSP_LONG);
    endfunction

endpackage

// File: rtl/sdrsp_crc7.sv
module sdrsp_crc7 (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    logic [6:0] crc_q;
    logic       fb;

    assign fb = din ^ crc_q[6];

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc_q <= '0;
        else if (en)
            crc_q <= {crc_q[5:3], crc_q[2] ^ fb, crc_q[1:0], fb};
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdrsp_shift.sv
module sdrsp_shift
    import sdrsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 din,
    output logic [PAYLOAD_W-1:0] bits,
    output logic [CNT_W-1:0]     pos
);
    logic [PAYLOAD_W-1:0] bits_q;
    logic [CNT_W-1:0]     pos_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits_q <= '0;
            pos_q  <= '0;
        end else if (en) begin
            bits_q <= {bits_q[PAYLOAD_W-2:0], din};
            pos_q  <= pos_q + 1'b1;
        end
    end

    assign bits = bits_q;
    assign pos  = pos_q;
endmodule

// File: rtl/sdrsp_fifo.sv
module sdrsp_fifo
    import sdrsp_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                flush,
    input  logic                                load,
    input  logic [LVL_W-1:0]                    load_cnt,
    input  logic [FIFO_DEPTH-1:0][HW_W-1:0]     load_data,
    input  logic                                rd_en,
    output logic [HW_W-1:0]                     rd_data
);
    logic [FIFO_DEPTH-1:0][HW_W-1:0] mem_q;
    logic [LVL_W-1:0]                lvl_q;
    logic [LVL_W-1:0]                ptr_q;
    logic                            has_data;

    assign has_data = ptr_q < lvl_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            lvl_q <= '0;
            ptr_q <= '0;
        end else if (load) begin
            mem_q <= load_data;
            lvl_q <= load_cnt;
            ptr_q <= '0;
        end else if (rd_en && has_data) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign rd_data = has_data ? mem_q[ptr_q[IDX_W-1:0]] : '0;

    p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= LVL_W'(FIFO_DEPTH));
    p_ptr_in_range_r9: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= lvl_q);
    p_empty_read_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !has_data && !load && !flush) |=> $stable(ptr_q));
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (lvl_q == '0) && (rd_data == '0));
endmodule

// File: rtl/sdrsp_capture.sv
module sdrsp_capture
    import sdrsp_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic [1:0]       rsp_kind,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             cmd_in,
    input  logic [2:0]       sts_clr,
    input  logic             rd_en,
    output logic [15:0]      rd_data,
    output logic             sts_end,
    output logic             sts_tmo,
    output logic             sts_crc
);
    rx_state_e            st_q;
    rsp_kind_e            kind_q;
    logic [TMO_W-1:0]     wait_q;
    rx_flags_t            flags_q;
    rx_flags_t            flags_set;

    logic                 shift_en;
    logic                 crc_en;
    logic                 last_bit;
    logic                 tmo_hit;
    logic                 load;
    logic                 crc_bad;
    logic                 is_long;
    logic [PAYLOAD_W-1:0] bits;
    logic [CNT_W-1:0]     pos;
    logic [6:0]           crc_calc;
    logic [PAYLOAD_W:0]   full;
    logic [LVL_W-1:0]     load_cnt;
    logic [FIFO_DEPTH-1:0][HW_W-1:0] load_data;

    // ---------------- control ----------------
    assign shift_en = !cmd_start &&
                      (((st_q == ST_WAIT) && !cmd_in) || (st_q == ST_SHIFT));
    assign crc_en   = shift_en && crc_covers(kind_q, pos);
    assign last_bit = (st_q == ST_SHIFT) && (pos == frame_last(kind_q));
    assign load     = last_bit && !cmd_start;
    assign tmo_hit  = !cmd_start && (st_q == ST_WAIT) && cmd_in &&
                      (({1'b0, wait_q} + 1'b1) >= {1'b0, tmo_limit});
    assign crc_bad  = crc_checked(kind_q) && (crc_calc != bits[6:0]);
    assign is_long  = (kind_q == RSP_LONG);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            kind_q <= RSP_NONE;
            wait_q <= '0;
        end else if (cmd_start) begin
            kind_q <= rsp_kind_e'(rsp_kind);
            wait_q <= '0;
            st_q   <= (rsp_kind_e'(rsp_kind) == RSP_NONE) ? ST_IDLE : ST_WAIT;
        end else begin
            unique case (st_q)
                ST_WAIT: begin
                    if (!cmd_in)
                        st_q <= ST_SHIFT;
                    else if (tmo_hit)
                        st_q <= ST_IDLE;
                    else
                        wait_q <= wait_q + 1'b1;
                end
                ST_SHIFT: if (last_bit) st_q <= ST_IDLE;
                default: ;
            endcase
        end
    end

    // ---------------- status flags ----------------
    always_comb begin
        flags_set.done = (cmd_start && (rsp_kind_e'(rsp_kind) == RSP_NONE)) || tmo_hit || load;
        flags_set.tmo  = tmo_hit;
        flags_set.crc  = load && crc_bad;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~rx_flags_t'(sts_clr)) | flags_set;
    end

    assign sts_end = flags_q.done;
    assign sts_tmo = flags_q.tmo;
    assign sts_crc = flags_q.crc;

    // ---------------- datapath ----------------
    sdrsp_shift u_shift (
        .clk  (clk),
        .rst  (rst),
        .clr  (cmd_start),
        .en   (shift_en),
        .din  (cmd_in),
        .bits (bits),
        .pos  (pos)
    );

    sdrsp_crc7 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (cmd_start),
        .en  (crc_en),
        .din (cmd_in),
        .crc (crc_calc)
    );

    assign full     = {bits, cmd_in};
    assign load_cnt = is_long ? LVL_W'(LONG_HW) : LVL_W'(SHORT_HW);

    for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_slot
        if (i < SHORT_HW) begin : g_both
            assign load_data[i] = is_long ? full[LONG_TOP - HW_W*i -: HW_W]
                                          : full[SHORT_TOP - HW_W*i -: HW_W];
        end else begin : g_long
            assign load_data[i] = is_long ? full[LONG_TOP - HW_W*i -: HW_W] : '0;
        end
    end

    sdrsp_fifo u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (cmd_start),
        .load      (load),
        .load_cnt  (load_cnt),
        .load_data (load_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data)
    );

    // ---------------- assertions ----------------
    p_no_reply_done_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && rsp_kind == 2'd0) |=> sts_end && (st_q == ST_IDLE));
    p_shift_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHIFT) |-> (pos <= frame_last(kind_q)) && (pos != '0));
    p_raw_never_crc_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_crc) |-> crc_checked(kind_q));
    p_tmo_also_done_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_tmo) |-> sts_end);
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_clr[1] && !tmo_hit) |=> !sts_tmo);
endmodule

// File: tb/tb_sdrsp_capture.sv
`timescale 1ns/1ps
module tb_sdrsp_capture;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_start;
    logic [1:0]  rsp_kind;
    logic [7:0]  tmo_limit;
    logic        cmd_in;
    logic [2:0]  sts_clr;
    logic        rd_en;
    logic [15:0] rd_data;
    logic        sts_end, sts_tmo, sts_crc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    sdrsp_capture #(.TMO_W(8)) dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .rsp_kind(rsp_kind),
        .tmo_limit(tmo_limit), .cmd_in(cmd_in), .sts_clr(sts_clr), .rd_en(rd_en),
        .rd_data(rd_data), .sts_end(sts_end), .sts_tmo(sts_tmo), .sts_crc(sts_crc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7(input logic [135:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [135:0] short_frame(input logic [5:0] idx, input logic [31:0] arg,
                                                 input bit bad);
        logic [39:0] h = {2'b00, idx, arg};
        logic [6:0]  c = crc7({96'd0, h}, 40) ^ (bad ? 7'h11 : 7'h00);
        return {88'd0, h, c, 1'b1};
    endfunction

    function automatic logic [135:0] long_frame(input logic [7:0] hdr, input logic [119:0] p,
                                                input bit bad);
        logic [6:0] c = crc7({16'd0, p}, 120) ^ (bad ? 7'h40 : 7'h00);
        return {hdr, p, c, 1'b1};
    endfunction

    task automatic clear_all();
        sts_clr = 3'b111;
        @(negedge clk);
        sts_clr = 3'b000;
    endtask

    task automatic issue(input logic [1:0] k);
        cmd_start = 1'b1;
        rsp_kind  = k;
        cmd_in    = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send(input string tag, input logic [135:0] f, input int n, input int gap);
        repeat (gap) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            cmd_in = f[i];
            if (i == 0) chk({tag, " done not early"}, {31'd0, sts_end}, 32'd0);
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic drain(input string tag, input logic [135:0] f, input int top, input int n);
        for (int i = 0; i < n; i++) begin
            chk(tag, {16'd0, rd_data}, {16'd0, f[top - 16*i -: 16]});
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk("R9 empty after drain", {16'd0, rd_data}, 32'd0);
    endtask

    // R1
    task automatic t_no_reply();
        clear_all();
        issue(2'd0);
        chk("R1 done", {31'd0, sts_end}, 32'd1);
        chk("R1 no tmo", {31'd0, sts_tmo}, 32'd0);
        chk("R1 fifo empty", {16'd0, rd_data}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R1 still no tmo", {31'd0, sts_tmo}, 32'd0);
    endtask

    // R2 R4
    task automatic t_short_ok();
        logic [135:0] f = short_frame(6'd17, 32'hA5C3_1E07, 1'b0);
        clear_all();
        issue(2'd1);
        send("R2", f, 48, 3);
        chk("R2 done", {31'd0, sts_end}, 32'd1);
        chk("R4 crc good", {31'd0, sts_crc}, 32'd0);
        chk("R2 last byte", {24'd0, f[15:8]}, 32'h07);
        drain("R2 halfword", f, 47, 3);
    endtask

    // R4
    task automatic t_short_bad();
        logic [135:0] f = short_frame(6'd5, 32'h0000_FFFF, 1'b1);
        clear_all();
        issue(2'd1);
        send("R4", f, 48, 0);
        chk("R4 crc error", {31'd0, sts_crc}, 32'd1);
        chk("R4 done", {31'd0, sts_end}, 32'd1);
    endtask

    // R6
    task automatic t_short_raw();
        logic [135:0] f = short_frame(6'd41, 32'h1357_9BDF, 1'b1);
        clear_all();
        issue(2'd3);
        send("R6", f, 48, 2);
        chk("R6 no crc check", {31'd0, sts_crc}, 32'd0);
        drain("R6 halfword", f, 47, 3);
    endtask

    // R3 R5
    task automatic t_long();
        logic [119:0] p = {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C, 24'h4B5A69};
        logic [135:0] f = long_frame(8'h3F, p, 1'b0);
        logic [135:0] g = long_frame(8'h00, p, 1'b0);
        logic [135:0] h = long_frame(8'h3F, p, 1'b1);
        clear_all();
        issue(2'd2);
        send("R3", f, 136, 1);
        chk("R3 done", {31'd0, sts_end}, 32'd1);
        chk("R5 crc good", {31'd0, sts_crc}, 32'd0);
        drain("R3 halfword", f, 127, 8);
        clear_all();
        issue(2'd2);
        send("R5", g, 136, 0);
        chk("R5 header not covered", {31'd0, sts_crc}, 32'd0);
        clear_all();
        issue(2'd2);
        send("R5", h, 136, 0);
        chk("R5 crc error", {31'd0, sts_crc}, 32'd1);
    endtask

    // R7 R8
    task automatic t_timeout();
        clear_all();
        tmo_limit = 8'd20;
        issue(2'd1);
        repeat (19) @(negedge clk);
        chk("R7 tmo not early", {31'd0, sts_tmo}, 32'd0);
        @(negedge clk);
        chk("R7 tmo", {31'd0, sts_tmo}, 32'd1);
        chk("R7 done", {31'd0, sts_end}, 32'd1);
        chk("R7 fifo empty", {16'd0, rd_data}, 32'd0);
        sts_clr = 3'b010;
        @(negedge clk);
        sts_clr = 3'b000;
        chk("R8 tmo cleared", {31'd0, sts_tmo}, 32'd0);
        chk("R8 done kept", {31'd0, sts_end}, 32'd1);
        sts_clr = 3'b001;
        @(negedge clk);
        sts_clr = 3'b000;
        chk("R8 done cleared", {31'd0, sts_end}, 32'd0);
    endtask

    // R11
    task automatic t_boundary();
        logic [135:0] f = short_frame(6'd2, 32'hCAFE_0001, 1'b0);
        clear_all();
        tmo_limit = 8'd20;
        issue(2'd1);
        send("R11", f, 48, 19);
        chk("R11 no tmo", {31'd0, sts_tmo}, 32'd0);
        chk("R11 done", {31'd0, sts_end}, 32'd1);
        chk("R11 first halfword", {16'd0, rd_data}, {16'd0, f[47:32]});
        tmo_limit = 8'hFF;
    endtask

    // R9 R10
    task automatic t_flush();
        logic [135:0] f = short_frame(6'd9, 32'h8421_F00D, 1'b0);
        clear_all();
        issue(2'd3);
        send("R10", f, 48, 0);
        chk("R9 head", {16'd0, rd_data}, {16'd0, f[47:32]});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 advance", {16'd0, rd_data}, {16'd0, f[31:16]});
        issue(2'd0);
        chk("R10 flushed", {16'd0, rd_data}, 32'd0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 empty read zero", {16'd0, rd_data}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_start = 1'b0; rsp_kind = 2'd0; tmo_limit = 8'hFF;
        cmd_in = 1'b1; sts_clr = 3'b000; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset done", {31'd0, sts_end}, 32'd0);
        chk("reset tmo", {31'd0, sts_tmo}, 32'd0);
        chk("reset crc", {31'd0, sts_crc}, 32'd0);
        chk("reset R9 data", {16'd0, rd_data}, 32'd0);
        t_no_reply();
        t_short_ok();
        t_short_bad();
        t_short_raw();
        t_long();
        t_timeout();
        t_boundary();
        t_flush();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule